// File: doc/BRIEF.md
# Command Slot Scheduler with Queued-Tag Tracking

This block sits inside one storage port and decides which issued command slot goes next to the command engine. Software sets bits in a 32-slot issue register. While the port is started, a scanner picks the lowest set slot and offers it to the engine. A slot is retired in one of two ways. It can be retired at once, on the cycle the engine accepts it. Or, if the engine is still busy with that command, the slot is parked in a hold state and retired when the engine reports idle.

Queued (native command queuing) reads and writes are handled differently. The engine returns the tag field of the command frame. The tag index is bits [7:3] of that field, and it is recorded in an active-tag register. Issuing a tag that is already active is rejected and flagged. The engine reports per-tag completions. Each one clears the active bit, adds the tag to a finished mask and raises a set-device-bits interrupt. The completion also updates the status and error bytes that go into the set-device-bits report. A read strobe on the active-tag register reconciles it against the finished mask and then clears the mask. A port reset aborts everything in flight.

The controller uses three named states:
- SCAN: idle and looking for work.
- ISSUE: a slot is being offered and the block waits for the engine to accept it.
- HOLD: an accepted non-queued command has left the engine busy.

It uses these transitions:
- SCAN→ISSUE when the port is started, a slot is pending, and both BSY and DRQ are low.
- ISSUE→SCAN on an accept when the slot is retired immediately.
- ISSUE→HOLD on an accept of a non-queued command while BSY or DRQ is high.
- HOLD→SCAN once BSY and DRQ are both low.
- Any state→SCAN on a port reset.

Top module: `cmd_slot_sched`

## Requirements
- R1: A write to the issue register ORs the written bits into it. Outside a slot retirement or a port reset, no bit of the register ever goes from 1 to 0.
- R2: A slot is offered only while `start_en` is high and the issue register is nonzero. Pending slots are offered lowest index first.
- R3: No slot is offered on the cycle after BSY or DRQ was high.
- R4: A non-queued command accepted with BSY and DRQ both low has its issue bit cleared at the accepting clock edge, and scanning resumes.
- R5: A non-queued command accepted with BSY or DRQ high keeps its issue bit set. `busy_valid` and `busy_slot` show the held slot until BSY and DRQ are both low. The issue bit is cleared at that edge.
- R6: A queued command sets active-tag bit `ack_tag_field[7:3]` (bits [2:0] are ignored) and clears its issue bit at the accepting edge.
- R7: A queued command whose tag is already active leaves the active-tag register unchanged, clears its issue bit, and pulses `dup_tag_err` for one cycle.
- R8: A tag completion clears that active bit and ORs the tag into `finished` at the same edge. `sdb_irq` is high for exactly the following cycle.
- R9: The report status byte equals the completion status ANDed with 0x77. A good completion reports status 0x50 and error 0x00. A failed completion reports status 0x41 and error 0x04, and sets the tag's bit in `serror`.
- R10: An `sact_rd` pulse clears every bit of the active-tag register that is set in `finished`, and clears `finished`, at the same edge.
- R11: `port_reset` clears the issue register, the active-tag register, `finished` and the hold state at the next edge, and returns to SCAN. `serror` is kept.
- R12: After `rst_n` every register output is zero and no slot is offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| port_reset | input | 1 | Port reset pulse; aborts slots and tags |
| start_en | input | 1 | Port started; enables scanning |
| ci_wr_en | input | 1 | Issue-register write strobe |
| ci_wr_data | input | NUM_SLOTS | Bits to OR into the issue register |
| eng_bsy | input | 1 | Engine busy status |
| eng_drq | input | 1 | Engine data-request status |
| disp_valid | output | 1 | A slot is being offered to the engine |
| disp_slot | output | SLOT_W | Index of the offered slot |
| eng_ack | input | 1 | Engine accepts the offered slot |
| ack_queued | input | 1 | Accepted command is a queued read/write |
| ack_tag_field | input | 8 | Frame tag field; tag index in bits [7:3] |
| tag_done_valid | input | 1 | Queued tag completion pulse |
| tag_done_tag | input | SLOT_W | Completed tag index |
| tag_done_err | input | 1 | Completion ended with an error |
| sact_rd | input | 1 | Active-tag register read strobe |
| cmd_issue | output | NUM_SLOTS | Issue register |
| busy_valid | output | 1 | A slot is held waiting for engine idle |
| busy_slot | output | SLOT_W | Held slot index |
| sactive | output | NUM_SLOTS | Active queued tags |
| finished | output | NUM_SLOTS | Finished-tag mask for the set-device-bits report |
| serror | output | NUM_SLOTS | Tags that completed with an error |
| sdb_status | output | 8 | Report status byte |
| sdb_error | output | 8 | Report error byte |
| sdb_irq | output | 1 | Set-device-bits interrupt pulse |
| dup_tag_err | output | 1 | Duplicate-tag rejection pulse |

## Verification
The hardest case to reach from the ports is the reconcile effect of R10. It only shows when a bit is set in both the active-tag register and `finished` at once. A normal completion clears the active bit before any read can happen. To create the overlap, the stimulus completes tag 3, then re-issues tag 3 through a fresh slot before reading, so the new active bit coexists with the stale finished bit. The read is then expected to drop the new active bit. The hold path of R5 is reached by asserting DRQ on the accepting cycle and keeping it high over several edges.

// File: rtl/cmd_slot_sched_pkg.sv
`timescale 1ns/1ps
package cmd_slot_sched_pkg;

    typedef enum logic [1:0] {
        ST_SCAN  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_HOLD  = 2'd2
    } sched_state_t;

    localparam int          TAG_FIELD_W    = 8;
    localparam int          TAG_SHIFT      = 3;
    localparam logic [7:0]  DSTAT_READY    = 8'h40;
    localparam logic [7:0]  DSTAT_SEEK     = 8'h10;
    localparam logic [7:0]  DSTAT_ERR      = 8'h01;
    localparam logic [7:0]  DERR_ABORT     = 8'h04;
    localparam logic [7:0]  SDB_STAT_MASK  = 8'h77;

endpackage

// File: rtl/cmd_slot_sched_lowbit.sv
`timescale 1ns/1ps
module cmd_slot_sched_lowbit #(
    parameter int N     = 32,
    parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     vec,
    output logic             found,
    output logic [IDX_W-1:0] idx
);

    // Walk from the top down so the lowest set bit is the last one written.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/cmd_slot_sched_tags.sv
`timescale 1ns/1ps
module cmd_slot_sched_tags
    import cmd_slot_sched_pkg::*;
#(
    parameter int N_TAGS = 32,
    parameter int TAG_W  = (N_TAGS > 1) ? $clog2(N_TAGS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              port_reset,
    input  logic              set_valid,
    input  logic [TAG_W-1:0]  set_tag,
    input  logic              done_valid,
    input  logic [TAG_W-1:0]  done_tag,
    input  logic              done_err,
    input  logic              sact_rd,
    output logic [N_TAGS-1:0] sactive,
    output logic [N_TAGS-1:0] finished,
    output logic [N_TAGS-1:0] serror,
    output logic [7:0]        rep_status,
    output logic [7:0]        rep_error,
    output logic              sdb_irq
);

    logic [7:0] done_status;

    assign done_status = done_err ? (DSTAT_READY | DSTAT_ERR)
                                  : (DSTAT_READY | DSTAT_SEEK);

    for (genvar t = 0; t < N_TAGS; t++) begin : g_tag
        logic hit_set;
        logic hit_done;
        logic act_q;
        logic fin_q;
        logic err_q;

        assign hit_set  = set_valid  && (set_tag  == TAG_W'(t));
        assign hit_done = done_valid && (done_tag == TAG_W'(t));

        always_ff @(posedge clk) begin
            if (!rst_n || port_reset) begin
                act_q <= 1'b0;
                fin_q <= 1'b0;
            end else begin
                // read reconciles against the old finished bit first
                act_q <= ((act_q && !(sact_rd && fin_q)) || hit_set) && !hit_done;
                fin_q <= (fin_q && !sact_rd) || hit_done;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                err_q <= 1'b0;
            end else if (hit_done && done_err) begin
                err_q <= 1'b1;
            end
        end

        assign sactive[t]  = act_q;
        assign finished[t] = fin_q;
        assign serror[t]   = err_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rep_status <= 8'h00;
            rep_error  <= 8'h00;
            sdb_irq    <= 1'b0;
        end else begin
            sdb_irq <= done_valid && !port_reset;
            if (done_valid && !port_reset) begin
                rep_status <= done_status & SDB_STAT_MASK;
                rep_error  <= done_err ? DERR_ABORT : 8'h00;
            end
        end
    end

endmodule

// File: rtl/cmd_slot_sched.sv
`timescale 1ns/1ps
module cmd_slot_sched
    import cmd_slot_sched_pkg::*;
#(
    parameter int NUM_SLOTS = 32,
    parameter int SLOT_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   port_reset,
    input  logic                   start_en,
    input  logic                   ci_wr_en,
    input  logic [NUM_SLOTS-1:0]   ci_wr_data,
    input  logic                   eng_bsy,
    input  logic                   eng_drq,
    output logic                   disp_valid,
    output logic [SLOT_W-1:0]      disp_slot,
    input  logic                   eng_ack,
    input  logic                   ack_queued,
    input  logic [TAG_FIELD_W-1:0] ack_tag_field,
    input  logic                   tag_done_valid,
    input  logic [SLOT_W-1:0]      tag_done_tag,
    input  logic                   tag_done_err,
    input  logic                   sact_rd,
    output logic [NUM_SLOTS-1:0]   cmd_issue,
    output logic                   busy_valid,
    output logic [SLOT_W-1:0]      busy_slot,
    output logic [NUM_SLOTS-1:0]   sactive,
    output logic [NUM_SLOTS-1:0]   finished,
    output logic [NUM_SLOTS-1:0]   serror,
    output logic [7:0]             sdb_status,
    output logic [7:0]             sdb_error,
    output logic                   sdb_irq,
    output logic                   dup_tag_err
);

    sched_state_t             st_q, st_d;
    logic [NUM_SLOTS-1:0]     ci_q, ci_d;
    logic [SLOT_W-1:0]        cur_q;
    logic                     dup_q;
    logic                     pick_found;
    logic [SLOT_W-1:0]        pick_idx;
    logic                     eng_idle;
    logic [TAG_FIELD_W-1:0]   tag_shifted;
    logic [SLOT_W-1:0]        ack_tag;
    logic                     retire;
    logic                     take_pick;
    logic                     tag_set;
    logic                     tag_dup;
    logic [NUM_SLOTS-1:0]     retire_mask;

    assign eng_idle    = !eng_bsy && !eng_drq;
    assign tag_shifted = ack_tag_field >> TAG_SHIFT;
    assign ack_tag     = tag_shifted[SLOT_W-1:0];

    cmd_slot_sched_lowbit #(
        .N     (NUM_SLOTS),
        .IDX_W (SLOT_W)
    ) u_pick (
        .vec   (ci_q),
        .found (pick_found),
        .idx   (pick_idx)
    );

    // next-state and action decode
    always_comb begin
        st_d      = st_q;
        retire    = 1'b0;
        take_pick = 1'b0;
        tag_set   = 1'b0;
        tag_dup   = 1'b0;
        unique case (st_q)
            ST_SCAN: begin
                if (start_en && pick_found && eng_idle) begin
                    take_pick = 1'b1;
                    st_d      = ST_ISSUE;
                end
            end
            ST_ISSUE: begin
                if (eng_ack) begin
                    if (ack_queued) begin
                        retire = 1'b1;
                        if (sactive[ack_tag]) begin
                            tag_dup = 1'b1;
                        end else begin
                            tag_set = 1'b1;
                        end
                        st_d = ST_SCAN;
                    end else if (!eng_idle) begin
                        st_d = ST_HOLD;
                    end else begin
                        retire = 1'b1;
                        st_d   = ST_SCAN;
                    end
                end
            end
            ST_HOLD: begin
                if (eng_idle) begin
                    retire = 1'b1;
                    st_d   = ST_SCAN;
                end
            end
            default: st_d = ST_SCAN;
        endcase
        if (port_reset) begin
            st_d      = ST_SCAN;
            retire    = 1'b0;
            take_pick = 1'b0;
            tag_set   = 1'b0;
            tag_dup   = 1'b0;
        end
    end

    assign retire_mask = retire ? (NUM_SLOTS'(1) << cur_q) : '0;

    always_comb begin
        if (port_reset) begin
            ci_d = '0;
        end else begin
            ci_d = (ci_q & ~retire_mask) | (ci_wr_en ? ci_wr_data : '0);
        end
    end

    // state register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_SCAN;
            ci_q  <= '0;
            cur_q <= '0;
            dup_q <= 1'b0;
        end else begin
            st_q  <= st_d;
            ci_q  <= ci_d;
            dup_q <= tag_dup;
            if (take_pick) begin
                cur_q <= pick_idx;
            end
        end
    end

    // output process
    always_comb begin
        disp_valid  = (st_q == ST_ISSUE);
        busy_valid  = (st_q == ST_HOLD);
        disp_slot   = cur_q;
        busy_slot   = cur_q;
        cmd_issue   = ci_q;
        dup_tag_err = dup_q;
    end

    cmd_slot_sched_tags #(
        .N_TAGS (NUM_SLOTS),
        .TAG_W  (SLOT_W)
    ) u_tags (
        .clk        (clk),
        .rst_n      (rst_n),
        .port_reset (port_reset),
        .set_valid  (tag_set),
        .set_tag    (ack_tag),
        .done_valid (tag_done_valid),
        .done_tag   (tag_done_tag),
        .done_err   (tag_done_err),
        .sact_rd    (sact_rd),
        .sactive    (sactive),
        .finished   (finished),
        .serror     (serror),
        .rep_status (sdb_status),
        .rep_error  (sdb_error),
        .sdb_irq    (sdb_irq)
    );

endmodule

// File: rtl/cmd_slot_sched_chk.sv
`timescale 1ns/1ps
module cmd_slot_sched_chk #(
    parameter int NUM_SLOTS = 32,
    parameter int SLOT_W    = 5
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 port_reset,
    input logic                 start_en,
    input logic                 eng_bsy,
    input logic                 eng_drq,
    input logic                 disp_valid,
    input logic                 busy_valid,
    input logic [SLOT_W-1:0]    busy_slot,
    input logic [NUM_SLOTS-1:0] cmd_issue,
    input logic [NUM_SLOTS-1:0] sactive,
    input logic [NUM_SLOTS-1:0] finished,
    input logic                 tag_done_valid,
    input logic                 sact_rd,
    input logic                 sdb_irq
);

    a_r1_no_silent_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (!port_reset && !disp_valid && !busy_valid) |=> (($past(cmd_issue) & ~cmd_issue) == '0));

    a_r2_offer_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(disp_valid) |-> $past(start_en));

    a_r3_offer_needs_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(disp_valid) |-> $past(!eng_bsy && !eng_drq));

    a_r5_hold_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_valid && (eng_bsy || eng_drq) && !port_reset) |=> (busy_valid && $stable(busy_slot)));

    a_r8_irq_follows_done: assert property (@(posedge clk) disable iff (!rst_n)
        (tag_done_valid && !port_reset) |=> sdb_irq);

    a_r10_read_empties_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (sact_rd && !tag_done_valid && !port_reset) |=> (finished == '0));

    a_r11_port_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
        port_reset |=> (cmd_issue == '0 && sactive == '0 && finished == '0 && !busy_valid));

    a_r2_single_role: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({disp_valid, busy_valid}));

endmodule

bind cmd_slot_sched cmd_slot_sched_chk #(
    .NUM_SLOTS (NUM_SLOTS),
    .SLOT_W    (SLOT_W)
) u_chk (.*);

// File: tb/cmd_slot_sched_tb.sv
`timescale 1ns/1ps
module cmd_slot_sched_tb;

    localparam int NS = 32;
    localparam int SW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          port_reset = 1'b0;
    logic          start_en = 1'b0;
    logic          ci_wr_en = 1'b0;
    logic [NS-1:0] ci_wr_data = '0;
    logic          eng_bsy = 1'b0;
    logic          eng_drq = 1'b0;
    logic          disp_valid;
    logic [SW-1:0] disp_slot;
    logic          eng_ack = 1'b0;
    logic          ack_queued = 1'b0;
    logic [7:0]    ack_tag_field = '0;
    logic          tag_done_valid = 1'b0;
    logic [SW-1:0] tag_done_tag = '0;
    logic          tag_done_err = 1'b0;
    logic          sact_rd = 1'b0;
    logic [NS-1:0] cmd_issue;
    logic          busy_valid;
    logic [SW-1:0] busy_slot;
    logic [NS-1:0] sactive;
    logic [NS-1:0] finished;
    logic [NS-1:0] serror;
    logic [7:0]    sdb_status;
    logic [7:0]    sdb_error;
    logic          sdb_irq;
    logic          dup_tag_err;

    int n_checks = 0;
    int n_fails  = 0;
    bit done_flag = 1'b0;

    always #2.5 clk = ~clk;

    cmd_slot_sched #(.NUM_SLOTS(NS)) u_dut (.*);

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic ci_write(input logic [NS-1:0] v);
        ci_wr_en = 1'b1; ci_wr_data = v;
        @(negedge clk);
        ci_wr_en = 1'b0; ci_wr_data = '0;
    endtask

    // wait for an offer, check slot, accept it; bsy/drq take given values at accept
    task automatic accept(input int exp_slot, input bit q, input logic [7:0] fld,
                          input bit bsy, input bit drq);
        int n = 0;
        while (!disp_valid && n < 20) begin @(negedge clk); n++; end
        chk(disp_valid && disp_slot == SW'(exp_slot), "R2 offer order",
            {27'd0, disp_slot}, exp_slot);
        eng_ack = 1'b1; ack_queued = q; ack_tag_field = fld;
        eng_bsy = bsy; eng_drq = drq;
        @(negedge clk);
        eng_ack = 1'b0; ack_queued = 1'b0; ack_tag_field = '0;
    endtask

    task automatic complete(input int tag, input bit err);
        tag_done_valid = 1'b1; tag_done_tag = SW'(tag); tag_done_err = err;
        @(negedge clk);
        tag_done_valid = 1'b0; tag_done_err = 1'b0;
    endtask

    task automatic t_reset_state();
        chk(cmd_issue == 0 && sactive == 0 && finished == 0 && serror == 0,
            "R12 regs zero", cmd_issue | sactive | finished, 0);
        chk(!disp_valid && !busy_valid && !sdb_irq, "R12 no offer",
            {disp_valid, busy_valid, sdb_irq}, 0);
    endtask

    task automatic t_or_and_start();
        start_en = 1'b0;
        ci_write(32'h5);
        ci_write(32'h2);
        chk(cmd_issue == 32'h7, "R1 OR write", cmd_issue, 32'h7);
        ci_write(32'h0);
        chk(cmd_issue == 32'h7, "R1 zero write keeps bits", cmd_issue, 32'h7);
        begin
            bit seen = 1'b0;
            for (int i = 0; i < 6; i++) begin @(negedge clk); seen |= disp_valid; end
            chk(!seen, "R2 stopped port offers nothing", seen, 0);
        end
    endtask

    task automatic t_order();
        start_en = 1'b1;
        accept(0, 1'b0, 8'h00, 1'b0, 1'b0);
        chk(cmd_issue == 32'h6, "R4 immediate retire", cmd_issue, 32'h6);
        accept(1, 1'b0, 8'h00, 1'b0, 1'b0);
        accept(2, 1'b0, 8'h00, 1'b0, 1'b0);
        chk(cmd_issue == 32'h0, "R4 all retired", cmd_issue, 0);
    endtask

    task automatic t_busy();
        bit seen = 1'b0;
        eng_bsy = 1'b1;
        ci_write(32'h10);
        for (int i = 0; i < 5; i++) begin @(negedge clk); seen |= disp_valid; end
        chk(!seen, "R3 no offer while BSY", seen, 0);
        eng_bsy = 1'b0; eng_drq = 1'b1;
        for (int i = 0; i < 4; i++) begin @(negedge clk); seen |= disp_valid; end
        chk(!seen, "R3 no offer while DRQ", seen, 0);
        eng_drq = 1'b0;
        accept(4, 1'b0, 8'h00, 1'b0, 1'b1);
        chk(busy_valid && busy_slot == 5'd4 && cmd_issue == 32'h10, "R5 hold entered",
            {busy_valid, 26'd0, busy_slot}, 32'h80000004);
        repeat (3) @(negedge clk);
        chk(busy_valid && cmd_issue == 32'h10, "R5 hold kept", cmd_issue, 32'h10);
        eng_drq = 1'b0;
        @(negedge clk);
        chk(!busy_valid && cmd_issue == 32'h0, "R5 retired on idle", cmd_issue, 0);
    endtask

    task automatic t_queued();
        ci_write(32'h1);
        accept(0, 1'b1, 8'h18, 1'b0, 1'b0);
        chk(sactive == 32'h8 && cmd_issue == 0, "R6 tag 3 active", sactive, 32'h8);
        ci_write(32'h2);
        accept(1, 1'b1, 8'h1D, 1'b0, 1'b0);
        chk(dup_tag_err == 1'b1, "R7 duplicate flagged", dup_tag_err, 1);
        chk(sactive == 32'h8 && cmd_issue == 0, "R7 duplicate no change", sactive, 32'h8);
        @(negedge clk);
        chk(dup_tag_err == 1'b0, "R7 flag one cycle", dup_tag_err, 0);
        ci_write(32'h1);
        accept(0, 1'b1, 8'h48, 1'b0, 1'b0);
        chk(sactive == 32'h208, "R6 tag 9 active", sactive, 32'h208);
    endtask

    task automatic t_done();
        complete(3, 1'b0);
        chk(sactive == 32'h200 && finished == 32'h8, "R8 good completion",
            sactive, 32'h200);
        chk(sdb_irq == 1'b1, "R8 irq raised", sdb_irq, 1);
        chk(sdb_status == 8'h50 && sdb_error == 8'h00, "R9 good report",
            {sdb_status, sdb_error}, 16'h5000);
        @(negedge clk);
        chk(sdb_irq == 1'b0, "R8 irq one cycle", sdb_irq, 0);
        complete(9, 1'b1);
        chk(sactive == 0 && finished == 32'h208, "R8 second completion", finished, 32'h208);
        chk(serror == 32'h200, "R9 error bit", serror, 32'h200);
        chk(sdb_status == 8'h41 && sdb_error == 8'h04, "R9 error report",
            {sdb_status, sdb_error}, 16'h4104);
    endtask

    task automatic t_read();
        ci_write(32'h1);
        accept(0, 1'b1, 8'h18, 1'b0, 1'b0);
        chk(sactive == 32'h8 && finished == 32'h208, "R10 overlap set up", sactive, 32'h8);
        sact_rd = 1'b1;
        @(negedge clk);
        sact_rd = 1'b0;
        chk(sactive == 0, "R10 reconcile active", sactive, 0);
        chk(finished == 0, "R10 mask cleared", finished, 0);
    endtask

    task automatic t_port_reset();
        bit seen = 1'b0;
        ci_write(32'h1);
        accept(0, 1'b1, 8'h28, 1'b0, 1'b0);
        ci_write(32'h1);
        accept(0, 1'b1, 8'h30, 1'b0, 1'b0);
        complete(5, 1'b0);
        chk(sactive == 32'h40 && finished == 32'h20, "R11 setup", sactive, 32'h40);
        ci_write(32'h6);
        accept(1, 1'b0, 8'h00, 1'b1, 1'b0);
        chk(busy_valid == 1'b1, "R11 setup hold", busy_valid, 1);
        port_reset = 1'b1;
        @(negedge clk);
        port_reset = 1'b0;
        chk(cmd_issue == 0 && sactive == 0 && finished == 0 && !busy_valid,
            "R11 cleared", cmd_issue | sactive | finished, 0);
        chk(serror == 32'h200, "R11 serror kept", serror, 32'h200);
        eng_bsy = 1'b0;
        for (int i = 0; i < 5; i++) begin @(negedge clk); seen |= disp_valid; end
        chk(!seen, "R11 nothing left to offer", seen, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_or_and_start();
        t_order();
        t_busy();
        t_queued();
        t_done();
        t_read();
        t_port_reset();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done_flag) begin
            done_flag = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule